// File: doc/BRIEF.md
# Max-Min Fair Rate Allocator

This block divides a link capacity among up to `N_MAX` flows by progressive filling. After a start strobe it latches the capacity, a valid mask and one requested rate per flow. It then runs a series of rounds. Each round picks the outstanding flow with the smallest request. That flow receives either its full request or an equal split of the capacity still unassigned among the flows still waiting. The remaining capacity and the count of waiting flows are then reduced, and the next round begins.

Rates are unsigned fixed-point numbers `RW` bits wide. The block does not interpret the binary point, so any scaling works. The smallest request is found by a serial scan that visits one flow per cycle. The equal split is computed by a restoring divider that produces one quotient bit per cycle. The remainder of the division is not discarded: it stays in the remaining capacity and is available to later rounds. When all grants are assigned, a one-cycle done pulse is raised. The grants stay on the outputs until the next accepted start.

Top module: `maxmin_alloc`

## Requirements
- R1: After reset every grant is 0 and `done` is low.
- R2: Each round serves the pending flow whose request is smallest. Among equal requests, the lowest flow index is served first.
- R3: If the chosen request W satisfies W*N <= C, the flow is granted exactly W. Here C is the remaining capacity and N is the number of flows still pending, so a request exactly equal to C/N is granted in full.
- R4: If W*N > C, the flow is granted floor(C/N).
- R5: After each grant, C drops by the granted amount and N drops by one. The truncation remainder of C/N therefore stays in C for later rounds.
- R6: A flow whose `valid` bit is low at start gets grant 0. It is not counted in N and is never selected.
- R7: `done` is high for exactly one cycle, in the cycle after the last grant is written. The grants then hold their values until the next accepted start, which clears every grant to 0 at the same edge.
- R8: Timing is fixed. A round that grants the request takes `N_MAX`+2 cycles. A round that grants the share takes `N_MAX`+2+`RW` cycles. A round's grant appears on the outputs at the end of that round.
- R9: A start strobe that arrives while an allocation is in progress is ignored, together with its capacity, valid and request inputs.
- R10: A start with no valid flow pulses `done` in the cycle after the start edge, and every grant is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Starts an allocation; accepted only when idle |
| capacity | input | RW | Link capacity C, sampled at start |
| valid | input | N_MAX | Active flows, sampled at start |
| requests | input | N_MAX*RW | Requested rate of flow i in bits [i*RW +: RW] |
| grants | output | N_MAX*RW | Granted rate of flow i in bits [i*RW +: RW] |
| done | output | 1 | One-cycle pulse after the final grant |

## Verification
Every result has a fixed due cycle, counted from the edge that accepts start. The bench works out those cycles by adding up the round lengths, `N_MAX`+2 for a granted request and `N_MAX`+2+`RW` for a share. It uses this to build the expected grant vector and done level for every cycle of the run. The outputs are compared against that model at each falling edge, so a grant that arrives one cycle early or late fails just as a wrong value does. Before each new start, the bench also compares the held grants of the previous run.

// File: rtl/maxmin_alloc.sv
module maxmin_alloc #(
  parameter int N_MAX = 8,
  parameter int RW    = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [RW-1:0]       capacity,
  input  logic [N_MAX-1:0]    valid,
  input  logic [N_MAX*RW-1:0] requests,
  output logic [N_MAX*RW-1:0] grants,
  output logic                done
);
  localparam int IW = (N_MAX > 1) ? $clog2(N_MAX) : 1;
  localparam int NW = $clog2(N_MAX + 1);
  localparam int CW = (RW > 1) ? $clog2(RW) : 1;
  localparam logic [IW-1:0] LAST_IDX = IW'(N_MAX - 1);
  localparam logic [CW-1:0] LAST_BIT = CW'(RW - 1);

  typedef enum logic [2:0] {S_IDLE, S_SEARCH, S_CMP, S_DIV, S_GRANT} state_t;

  state_t            st;
  logic [RW-1:0]     req_q   [N_MAX];
  logic [RW-1:0]     grant_q [N_MAX];
  logic [N_MAX-1:0]  pend;
  logic [NW-1:0]     n_rem;
  logic [RW-1:0]     cap_rem;
  logic [IW-1:0]     idx, best;
  logic [RW-1:0]     best_val;
  logic              found, use_share, done_q;
  logic [RW-1:0]     quo;
  logic [NW-1:0]     rem;
  logic [CW-1:0]     cnt;

  logic [NW-1:0]     n_start;
  logic [RW+NW-1:0]  prod;
  logic [NW:0]       trial;
  logic              trial_ge;
  logic [NW-1:0]     trial_diff;
  logic [RW-1:0]     amt;

  always_comb begin
    n_start = '0;
    for (int i = 0; i < N_MAX; i++) n_start = n_start + NW'(valid[i]);
  end

  assign prod       = {{NW{1'b0}}, best_val} * {{RW{1'b0}}, n_rem};
  assign trial      = {rem, quo[RW-1]};
  assign trial_ge   = trial >= {1'b0, n_rem};
  assign trial_diff = trial[NW-1:0] - n_rem;
  assign amt        = use_share ? quo : best_val;
  assign done       = done_q;

  for (genvar g = 0; g < N_MAX; g++) begin : g_out
    assign grants[g*RW +: RW] = grant_q[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      pend      <= '0;
      n_rem     <= '0;
      cap_rem   <= '0;
      idx       <= '0;
      best      <= '0;
      best_val  <= '0;
      found     <= 1'b0;
      use_share <= 1'b0;
      quo       <= '0;
      rem       <= '0;
      cnt       <= '0;
      done_q    <= 1'b0;
      for (int i = 0; i < N_MAX; i++) begin
        req_q[i]   <= '0;
        grant_q[i] <= '0;
      end
    end else begin
      done_q <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          for (int i = 0; i < N_MAX; i++) begin
            req_q[i]   <= requests[i*RW +: RW];
            grant_q[i] <= '0;
          end
          pend    <= valid;
          n_rem   <= n_start;
          cap_rem <= capacity;
          idx     <= '0;
          found   <= 1'b0;
          if (n_start == '0) done_q <= 1'b1;
          else               st     <= S_SEARCH;
        end
        S_SEARCH: begin
          if (pend[idx] && (!found || req_q[idx] < best_val)) begin
            best     <= idx;
            best_val <= req_q[idx];
            found    <= 1'b1;
          end
          idx <= idx + 1'b1;
          if (idx == LAST_IDX) st <= S_CMP;
        end
        S_CMP: begin
          if (prod <= {{NW{1'b0}}, cap_rem}) begin
            use_share <= 1'b0;
            st        <= S_GRANT;
          end else begin
            use_share <= 1'b1;
            quo       <= cap_rem;
            rem       <= '0;
            cnt       <= '0;
            st        <= S_DIV;
          end
        end
        S_DIV: begin
          rem <= trial_ge ? trial_diff : trial[NW-1:0];
          quo <= {quo[RW-2:0], trial_ge};
          cnt <= cnt + 1'b1;
          if (cnt == LAST_BIT) st <= S_GRANT;
        end
        S_GRANT: begin
          grant_q[best] <= amt;
          pend[best]    <= 1'b0;
          cap_rem       <= cap_rem - amt;
          n_rem         <= n_rem - 1'b1;
          idx           <= '0;
          found         <= 1'b0;
          if (n_rem == NW'(1)) begin
            done_q <= 1'b1;
            st     <= S_IDLE;
          end else begin
            st <= S_SEARCH;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_pick_pending_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_CMP) |-> pend[best]);

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_GRANT) |-> (amt <= cap_rem));

  assert_count_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_GRANT) |=> (n_rem == NW'($past(n_rem) - 1'b1)));

  assert_share_floor_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_GRANT && use_share) |->
      (int'(amt) * int'(n_rem) <= int'(cap_rem)) &&
      ((int'(amt) + 1) * int'(n_rem) > int'(cap_rem)));

  assert_pending_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SEARCH) |-> ($countones(pend) == int'(n_rem)));

  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  assert_grant_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && !start) |=> $stable(grants));
endmodule

// File: tb/test_maxmin_alloc.sv
`timescale 1ns/1ps
module test_maxmin_alloc;
  localparam int NF = 8;
  localparam int RW = 16;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic [RW-1:0]     cap_in = '0;
  logic [NF-1:0]     valid_in = '0;
  logic [NF*RW-1:0]  req_bus = '0;
  logic [NF*RW-1:0]  grants;
  logic              done;

  int total = 0;
  int bad = 0;
  int rq [NF];
  logic [NF*RW-1:0] exp_bus = '0;

  always #4 clk = ~clk;

  maxmin_alloc #(.N_MAX(NF), .RW(RW)) i_maxmin_alloc (
    .clk(clk), .rst_n(rst_n), .start(start), .capacity(cap_in),
    .valid(valid_in), .requests(req_bus), .grants(grants), .done(done));

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic check(input string tag, input int cyc, input logic exp_done);
    total++;
    if (grants !== exp_bus) begin
      bad++;
      $display("FAIL %s/R8 cycle %0d grants act=%h exp=%h", tag, cyc, grants, exp_bus);
    end
    total++;
    if (done !== exp_done) begin
      bad++;
      $display("FAIL %s/R7 cycle %0d done act=%0b exp=%0b", tag, cyc, done, exp_done);
    end
  endtask

  task automatic run_case(input string tag, input int cap, input logic [NF-1:0] vm,
                          input bit disturb);
    int ev_e [NF];
    int ev_f [NF];
    int ev_a [NF];
    int nev = 0;
    int n, c, e, b, amt;
    logic [NF-1:0] pend;
    @(negedge clk);
    total++;
    if (grants !== exp_bus) begin
      bad++;
      $display("FAIL R7 held grants act=%h exp=%h", grants, exp_bus);
    end
    pend = vm; n = $countones(vm); c = cap; e = 0;
    while (n > 0) begin
      b = -1;
      for (int i = 0; i < NF; i++)
        if (pend[i] && (b < 0 || rq[i] < rq[b])) b = i;
      if (rq[b] * n <= c) begin amt = rq[b]; e += NF + 2; end
      else begin amt = c / n; e += NF + 2 + RW; end
      ev_e[nev] = e; ev_f[nev] = b; ev_a[nev] = amt; nev++;
      c -= amt; n--; pend[b] = 1'b0;
    end
    for (int i = 0; i < NF; i++) req_bus[i*RW +: RW] = rq[i][RW-1:0];
    cap_in = cap[RW-1:0];
    valid_in = vm;
    start = 1'b1;
    exp_bus = '0;
    for (int cyc = 0; cyc <= e + 2; cyc++) begin
      @(negedge clk);
      if (cyc == 0) start = 1'b0;
      if (disturb && cyc == 4) begin
        start = 1'b1; cap_in = 16'd7; valid_in = '1; req_bus = '1;
      end
      if (disturb && cyc == 5) start = 1'b0;
      for (int k = 0; k < nev; k++)
        if (ev_e[k] == cyc) exp_bus[ev_f[k]*RW +: RW] = ev_a[k][RW-1:0];
      check(tag, cyc, cyc == e);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    total++;
    if (grants !== '0 || done !== 1'b0) begin
      bad++;
      $display("FAIL R1 reset act=%h/%0b exp=0/0", grants, done);
    end
    rst_n = 1'b1;

    rq = '{26, 128, 2560, 1280, 0, 0, 0, 0};
    run_case("R4", 256, 8'h0F, 1'b0);
    rq = '{50, 40, 30, 20, 10, 0, 0, 0};
    run_case("R3", 1000, 8'h1F, 1'b0);
    rq = '{20, 20, 20, 20, 0, 0, 0, 0};
    run_case("R3", 80, 8'h0F, 1'b0);
    rq = '{100, 100, 100, 100, 100, 50, 100, 100};
    run_case("R2", 300, 8'hFF, 1'b0);
    rq = '{100, 100, 100, 0, 0, 0, 0, 0};
    run_case("R5", 10, 8'h07, 1'b0);
    rq = '{90, 1, 300, 1, 1, 40, 1, 500};
    run_case("R6", 400, 8'hA5, 1'b0);
    rq = '{5, 5, 5, 5, 5, 5, 5, 5};
    run_case("R10", 100, 8'h00, 1'b0);
    rq = '{60000, 9000, 20, 65535, 700, 12000, 3, 40000};
    run_case("R4", 65535, 8'hFF, 1'b0);
    rq = '{300, 7, 250, 90, 0, 0, 0, 0};
    run_case("R9", 500, 8'h0F, 1'b1);
    rq = '{1, 2, 3, 4, 5, 6, 7, 8};
    run_case("R7", 20, 8'hFF, 1'b0);

    repeat (3) @(negedge clk);
    check("R7", -1, 1'b0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule